// File: doc/BRIEF.md
# Bidirectional Gate-Scan Shift Register

This block is the scan logic of a display row driver. A single active bit, the scan token, enters the chip on one of two cascade pins. Each rising edge of the vertical shift clock moves it one stage along a 240-stage chain, and every stage drives one gate enable. When the token leaves the far end of the chain it appears on the opposite cascade pin, so the next driver in a cascade can pick it up.

One direction input sets the scan order and decides which cascade pin listens and which one drives. An active-low output enable forces every gate enable off without disturbing the chain. An active-low reset empties the chain at once and releases in step with the shift clock. Each cascade pin is split into an input, an output value and an output-driver enable, so a pad ring or a board model can close the bidirectional connection.

Top module: `gate_scan_chain`

## Requirements
- R1: With `dir` = 1, each rising edge of `clk` loads the value of `cas_a_i` into stage 0, visible on `gate_on[0]`, and moves every stage k to stage k+1. Bit k of `gate_on` is the gate line numbered k+1.
- R2: With `dir` = 0, each rising edge of `clk` loads the value of `cas_b_i` into stage 239, visible on `gate_on[239]`, and moves every stage k to stage k-1.
- R3: The driving cascade pin carries a register that takes the value of the last stage in the scan order on each falling edge of `clk`, and holds it across the rising edge. A token loaded on one rising edge reaches the driving pin after the falling edge that follows its 240th rising edge, counting the loading edge.
- R4: With `dir` = 1, `cas_b_oe` = 1 and `cas_a_oe` = 0. With `dir` = 0 the two are swapped. The `_o` value of the pin that is not driving is 0, and the `_i` value of the driving pin has no effect on the chain.
- R5: While `oe_n` = 1, all 240 bits of `gate_on` are 0. The chain keeps its contents, and they reappear once `oe_n` returns to 0.
- R6: While `rst_n` = 0, every stage and the cascade register are 0 without waiting for a clock edge, so `gate_on` and both cascade output values are 0.
- R7: After `rst_n` rises, the first two rising edges of `clk` keep the chain empty and ignore cascade input. Shifting starts on the third rising edge.
- R8: With a single token in flight, exactly one bit of `gate_on` is 1 after each of the 240 shifts while the token is inside the chain. None is 1 after the token leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Vertical shift clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| dir | input | 1 | Scan direction and cascade pin role select |
| oe_n | input | 1 | Active-low gate output enable |
| cas_a_i | input | 1 | Cascade pin A input value |
| cas_a_o | output | 1 | Cascade pin A output value |
| cas_a_oe | output | 1 | Cascade pin A driver enable |
| cas_b_i | input | 1 | Cascade pin B input value |
| cas_b_o | output | 1 | Cascade pin B output value |
| cas_b_oe | output | 1 | Cascade pin B driver enable |
| gate_on | output | 240 | Gate enables, bit k is line k+1 |

## Verification
A single token is walked through the whole chain in each direction. This shows where the token enters and in which order it moves, that it stays alone in the chain, and that it arrives on the far pin exactly after the 240th edge. A dense, irregular bit pattern separates a true shift from a stuck or skipped stage, and a constant 1 held on the wrong pin shows that the driving pin's input is ignored. Output-disable windows and a reset in the middle of a run show that disabling the outputs keeps the chain contents while a reset erases them. Each cycle the cascade value is sampled both before and after the falling edge, which confirms that it changes on the falling edge and not on the rising one.

// File: rtl/gate_scan_chain.sv
`timescale 1ns/1ps
module gate_scan_chain #(
  parameter int N_STAGES = 240
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dir,
  input  logic                oe_n,
  input  logic                cas_a_i,
  output logic                cas_a_o,
  output logic                cas_a_oe,
  input  logic                cas_b_i,
  output logic                cas_b_o,
  output logic                cas_b_oe,
  output logic [N_STAGES-1:0] gate_on
);
  localparam int LAST = N_STAGES - 1;

  logic [1:0]        rel;
  logic              run;
  logic [LAST:0]     stage;
  logic              tail;
  logic              cas_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rel <= '0;
    else        rel <= {rel[0], 1'b1};

  assign run = rel[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    stage <= '0;
    else if (!run) stage <= '0;
    else if (dir)  stage <= {stage[LAST-1:0], cas_a_i};
    else           stage <= {cas_b_i, stage[LAST:1]};

  assign tail = dir ? stage[LAST] : stage[0];

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) cas_q <= 1'b0;
    else        cas_q <= run & tail;

  assign gate_on  = oe_n ? '0 : stage;
  assign cas_a_oe = ~dir;
  assign cas_b_oe = dir;
  assign cas_a_o  = ~dir & cas_q;
  assign cas_b_o  = dir & cas_q;
endmodule

// File: rtl/gate_scan_chain_chk.sv
`timescale 1ns/1ps
module gate_scan_chain_chk #(
  parameter int N_STAGES = 240
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dir,
  input logic                oe_n,
  input logic                cas_a_i,
  input logic                cas_b_i,
  input logic                cas_a_o,
  input logic                cas_b_o,
  input logic                cas_a_oe,
  input logic                cas_b_oe,
  input logic [N_STAGES-1:0] gate_on,
  input logic [N_STAGES-1:0] stage,
  input logic                run
);
  localparam int LAST = N_STAGES - 1;

  // R1
  fwd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir) |=> stage[0] == $past(cas_a_i));

  // R1
  fwd_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir) |=> stage[LAST:1] == $past(stage[LAST-1:0]));

  // R2
  rev_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dir) |=> stage[LAST] == $past(cas_b_i));

  // R2
  rev_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dir) |=> stage[LAST-1:0] == $past(stage[LAST:1]));

  // R3
  cas_follow_chk: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> (dir ? cas_b_o : cas_a_o) == $past(dir ? stage[LAST] : stage[0]));

  // R4
  pin_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_b_oe == dir) && (cas_a_oe == !dir) && !(dir && cas_a_o) && !(!dir && cas_b_o));

  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> gate_on == '0);

  // R6
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (stage == '0) && (gate_on == '0) && !cas_a_o && !cas_b_o);

  // R7
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> stage == '0);
endmodule

bind gate_scan_chain gate_scan_chain_chk #(.N_STAGES(N_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .oe_n(oe_n),
  .cas_a_i(cas_a_i), .cas_b_i(cas_b_i),
  .cas_a_o(cas_a_o), .cas_b_o(cas_b_o),
  .cas_a_oe(cas_a_oe), .cas_b_oe(cas_b_oe),
  .gate_on(gate_on), .stage(stage), .run(run)
);

// File: tb/gate_scan_chain_bench.sv
`timescale 1ns/1ps
module gate_scan_chain_bench;
  localparam int N = 240;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, dir, oe_n, a_i, b_i;
  logic a_o, a_oe, b_o, b_oe;
  logic [N-1:0] gate_on;

  gate_scan_chain #(.N_STAGES(N)) u_gate_scan_chain (
    .clk(clk), .rst_n(rst_n), .dir(dir), .oe_n(oe_n),
    .cas_a_i(a_i), .cas_a_o(a_o), .cas_a_oe(a_oe),
    .cas_b_i(b_i), .cas_b_o(b_o), .cas_b_oe(b_oe),
    .gate_on(gate_on)
  );

  bit mdl[N];
  int q1, q2;
  bit mcas;
  int checks, fails;
  bit done;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mvec();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = mdl[k];
    return v;
  endfunction

  function automatic logic drv_pin();
    return dir ? b_o : a_o;
  endfunction

  task automatic mclear();
    for (int k = 0; k < N; k++) mdl[k] = 1'b0;
  endtask

  task automatic step(bit a, bit b);
    a_i = a;
    b_i = b;
    @(posedge clk);
    if (!rst_n) begin
      mclear(); q1 = 0; q2 = 0;
    end else begin
      if (q2 == 1) begin
        if (dir) begin
          for (int k = N - 1; k > 0; k--) mdl[k] = mdl[k-1];
          mdl[0] = a;
        end else begin
          for (int k = 0; k < N - 1; k++) mdl[k] = mdl[k+1];
          mdl[N-1] = b;
        end
      end else mclear();
      q2 = q1; q1 = 1;
    end
    #1;
    chk("R3 cascade held over rising edge", N'(drv_pin()), N'(mcas));
    #2;
    mcas = rst_n ? (dir ? mdl[N-1] : mdl[0]) : 1'b0;
    chk(dir ? "R1 forward chain" : "R2 reverse chain", gate_on, oe_n ? '0 : mvec());
    chk("R3 cascade after falling edge", N'(drv_pin()), N'(mcas));
    chk("R4 pin roles", N'({a_oe, b_oe, dir ? a_o : b_o}), N'({~dir, dir, 1'b0}));
  endtask

  task automatic walk_token();
    if (dir) step(1, 1); else step(1, 1);
    chk("R8 single active at entry", N'($countones(gate_on)), N'(1));
    for (int i = 1; i < N; i++) begin
      step(0, !dir ? 0 : 1);
      chk("R8 single active", N'($countones(gate_on)), N'(1));
    end
    chk("R3 token on far pin after 240 edges", N'(drv_pin()), N'(1));
    step(0, 0);
    chk("R8 token gone", gate_on, '0);
    chk("R3 far pin cleared", N'(drv_pin()), N'(0));
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; dir = 1'b1; oe_n = 1'b0; a_i = 1'b0; b_i = 1'b0;
    q1 = 0; q2 = 0; mcas = 0; mclear();
    #1;
    for (int i = 0; i < 3; i++) step(1, 1);
    chk("R6 reset state gates", gate_on, '0);
    chk("R6 reset state cascade", N'({a_o, b_o}), N'(0));

    rst_n = 1'b1;
    step(1, 0);
    chk("R7 first edge after release ignored", gate_on, '0);
    step(1, 0);
    chk("R7 second edge after release ignored", gate_on, '0);
    walk_token();

    for (int i = 0; i < 40; i++) begin
      oe_n = (i >= 15 && i < 20);
      step((i % 3 == 0) || (i % 7 == 2), 1);
      if (oe_n) chk("R5 outputs forced off", gate_on, '0);
    end
    oe_n = 1'b0;
    step(0, 0);
    chk("R5 contents back after enable", N'($countones(gate_on)), N'($countones(mvec())));

    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R6 asynchronous clear gates", gate_on, '0);
    chk("R6 asynchronous clear cascade", N'({a_o, b_o}), N'(0));
    mclear(); q1 = 0; q2 = 0; mcas = 0;
    step(0, 0);
    dir = 1'b0;
    step(1, 1);
    rst_n = 1'b1;
    step(0, 1);
    step(0, 1);
    chk("R7 reverse release held", gate_on, '0);
    walk_token();

    begin
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < 60; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        step(lf[1], lf[0]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule